// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small 8-bit accumulator processor that runs 16-bit instructions from a synchronous memory. The memory has separate read and write data buses. Each instruction has a 4-bit opcode in its top nibble and an 8-bit operand in its low byte. The operand is either a constant or an absolute memory address. The nibble between them is not decoded. The datapath holds an instruction register, an 8-bit program counter, a single 8-bit accumulator, an address multiplexer, a zero detector and an ALU. The ALU can add, subtract, take a bitwise AND, or pass its second operand straight through.

Every instruction takes three clock cycles, stepped by a one-hot ring counter: fetch, decode, execute. The controller combines the ring counter with a one-hot opcode decode. When the accumulator is written to memory, the undecoded nibble of the store instruction goes into the top nibble of the stored word. A program can use this to build new jump instructions at run time, for example to return from a subroutine.

Memory, I/O mapping and reset generation sit outside this block. The memory is expected to return read data on the cycle after an enabled access.

Top module: `acc_cpu`

## Requirements
- R1: When `rst_n` is low at a rising edge, the instruction register, program counter and accumulator clear to zero and the phase returns to fetch. While reset is held, the outputs show a fetch of address 0 (`mem_en` high, `mem_we` low). The first instruction after release comes from address 0.
- R2: Every instruction takes exactly three cycles. In the first cycle, `mem_addr` equals the program counter, `mem_en` is high and `mem_we` is low. At the end of that cycle the program counter advances by one.
- R3: The opcode is bits [15:12] and the operand is bits [7:0]. Bits [11:8] have no effect on what an instruction does.
- R4: The immediate opcodes are move 0x0 (ACC = K), add 0x1 (ACC + K), subtract 0x2 (ACC + ~K + 1) and AND 0x3 (ACC & K). All results are kept modulo 256.
- R5: The memory opcodes are load 0x4 (ACC = M[A][7:0]), add-memory 0x6 and subtract-memory 0x7. Each reads M[A] in the second cycle with `mem_en` high, `mem_we` low and `mem_addr` = A. Other opcodes leave `mem_en` low in the second cycle.
- R6: Store 0x5 drives `mem_en` and `mem_we` high in the third cycle, with `mem_addr` = A and `mem_wdata` = {IR[11:8], 4'h0, ACC}. The accumulator is not changed.
- R7: Jump 0x8 loads A into the program counter, so the next fetch is from A. This also works when the jump word was written by an earlier store.
- R8: Jump-if-zero 0x9 is taken only when ACC is 0x00. Jump-if-nonzero 0xA is taken only when ACC is not 0x00. When the jump is not taken, the next fetch is sequential.
- R9: Opcodes 0xB to 0xF change nothing: the accumulator keeps its value, nothing is written and the next fetch is sequential.
- R10: The accumulator changes only at the end of the third cycle. `mem_we` is high only in the third cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Memory address |
| mem_rdata | input | 16 | Read data, valid the cycle after an enabled access |
| mem_wdata | output | 16 | Write data for stores |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |

## Verification
Counting cycles from reset release as k, cycle 3k is always the fetch of instruction k. Its address can be compared on that same cycle. The operand read of that instruction appears in cycle 3k+1, and a store appears in cycle 3k+2.

Effects on the program counter show up in the fetch address of the following instruction, three cycles later. The accumulator has no port of its own, so its value is checked through later stores.

The bench samples every port 1 ns after each falling edge. It files each sample by the phase computed from its cycle count, so every comparison is made in the cycle in which the result is due.

// File: rtl/acc_cpu_pkg.sv
// Shared constants and types for the accumulator processor.
// Assumes an 8-bit datapath, 16-bit instructions and a 4-bit opcode field.
package acc_cpu_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned INSTR_W   = 16;
    localparam int unsigned OPC_W     = 4;
    localparam int unsigned NUM_PHASE = 3;

    // Phase bit positions in the one-hot ring
    localparam int unsigned PH_FETCH  = 0;
    localparam int unsigned PH_DECODE = 1;
    localparam int unsigned PH_EXEC   = 2;

    // Opcode values
    localparam logic [3:0] OPC_MOVE  = 4'h0;
    localparam logic [3:0] OPC_ADD   = 4'h1;
    localparam logic [3:0] OPC_SUB   = 4'h2;
    localparam logic [3:0] OPC_AND   = 4'h3;
    localparam logic [3:0] OPC_LOAD  = 4'h4;
    localparam logic [3:0] OPC_STORE = 4'h5;
    localparam logic [3:0] OPC_ADDM  = 4'h6;
    localparam logic [3:0] OPC_SUBM  = 4'h7;
    localparam logic [3:0] OPC_JUMP  = 4'h8;
    localparam logic [3:0] OPC_JZ    = 4'h9;
    localparam logic [3:0] OPC_JNZ   = 4'hA;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_PASS = 2'd3
    } alu_op_e;
endpackage

// File: rtl/acc_cpu_ring.sv
// One-hot ring counter that steps the fetch / decode / execute phases.
// Assumes a synchronous active-low reset that returns it to the fetch phase.
module acc_cpu_ring
    import acc_cpu_pkg::*;
#(
    parameter int unsigned N = NUM_PHASE
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] phase
);
    localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

    // Rotate the single hot bit one place per clock
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= START;
        else        phase <= {phase[N-2:0], phase[N-1]};
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
// Hardwired controller: one-hot opcode decode gated by the current phase.
// Assumes the opcode comes from the live memory word in decode and from
// the instruction register in execute.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned OW = OPC_W
) (
    input  logic [NUM_PHASE-1:0] phase,
    input  logic [OW-1:0]        opcode,
    input  logic                 acc_zero,
    output logic                 ir_ld,
    output logic                 pc_ce,
    output logic                 pc_ld,
    output logic                 addr_sel_opnd,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic                 acc_ce,
    output logic                 b_sel_mem,
    output alu_op_e              alu_op
);
    localparam int unsigned NUM_OPC = 1 << OW;

    logic [NUM_OPC-1:0] dec;
    logic ph_f, ph_d, ph_e;
    logic is_mem_rd, is_nop, take, writes_acc;

    // One decode line per opcode value
    for (genvar g = 0; g < NUM_OPC; g++) begin : g_dec
        assign dec[g] = (opcode == OW'(g));
    end

    assign ph_f = phase[PH_FETCH];
    assign ph_d = phase[PH_DECODE];
    assign ph_e = phase[PH_EXEC];

    assign is_mem_rd  = dec[OPC_LOAD] | dec[OPC_ADDM] | dec[OPC_SUBM];
    assign is_nop     = |dec[NUM_OPC-1:int'(OPC_JNZ)+1];
    assign take       = dec[OPC_JUMP] | (dec[OPC_JZ] & acc_zero) | (dec[OPC_JNZ] & ~acc_zero);
    assign writes_acc = (dec[OPC_MOVE] | dec[OPC_ADD] | dec[OPC_SUB] | dec[OPC_AND] | is_mem_rd) & ~is_nop;

    assign ir_ld         = ph_d;
    assign pc_ld         = ph_e & take;
    assign pc_ce         = ph_f | pc_ld;
    assign addr_sel_opnd = ~ph_f;
    assign mem_we        = ph_e & dec[OPC_STORE];
    assign mem_en        = ph_f | (ph_d & is_mem_rd) | mem_we;
    assign acc_ce        = ph_e & writes_acc;
    assign b_sel_mem     = is_mem_rd;

    // Choose the ALU function from the decoded opcode
    always_comb begin
        if (dec[OPC_ADD] | dec[OPC_ADDM])      alu_op = ALU_ADD;
        else if (dec[OPC_SUB] | dec[OPC_SUBM]) alu_op = ALU_SUB;
        else if (dec[OPC_AND])                 alu_op = ALU_AND;
        else                                   alu_op = ALU_PASS;
    end
endmodule

// File: rtl/acc_cpu_pc.sv
// Loadable program counter built from one adder and one input multiplexer.
// Increment is D=Q plus carry-in 1; load is D=operand plus carry-in 0.
module acc_cpu_pc
    import acc_cpu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] add_a, nxt;

    assign add_a = ld ? d : q;
    assign nxt   = add_a + {{(W-1){1'b0}}, ~ld};

    // Hold, step or load the counter
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ce) q <= nxt;
    end
endmodule

// File: rtl/acc_cpu_alu.sv
// Accumulator ALU: add, subtract (A + ~B + 1), bitwise AND, pass B.
// Assumes results wrap at the datapath width.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    logic          sub;
    logic [W-1:0]  b_x, sum;

    assign sub = (op == ALU_SUB);
    assign b_x = b ^ {W{sub}};
    assign sum = a + b_x + {{(W-1){1'b0}}, sub};

    // Output select among adder, AND and pass-through
    always_comb begin
        case (op)
            ALU_ADD, ALU_SUB: y = sum;
            ALU_AND:          y = a & b;
            default:          y = b;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
// Accumulator processor top: instruction register, accumulator, address
// and operand multiplexers, zero detect, store-word assembly.
// Assumes a memory whose read data arrives one cycle after an enabled access.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = INSTR_W,
    parameter int unsigned OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    input  logic [IW-1:0] mem_rdata,
    output logic [IW-1:0] mem_wdata,
    output logic          mem_en,
    output logic          mem_we
);
    localparam int unsigned SPARE_W = IW - OW - DW;
    localparam int unsigned GAP_W   = IW - SPARE_W - DW;

    logic [NUM_PHASE-1:0] phase_q;
    logic [IW-1:0]        ir_q;
    logic [DW-1:0]        pc_q, acc_q, operand, alu_b, alu_y;
    logic [OW-1:0]        opcode;
    logic ir_ld, pc_ce, pc_ld, addr_sel_opnd, acc_ce, b_sel_mem;
    alu_op_e alu_op;

    acc_cpu_ring #(.N(NUM_PHASE)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_q)
    );

    // Decode works on the word arriving from memory; execute on the IR
    assign opcode  = phase_q[PH_DECODE] ? mem_rdata[IW-1 -: OW] : ir_q[IW-1 -: OW];
    assign operand = phase_q[PH_DECODE] ? mem_rdata[DW-1:0]     : ir_q[DW-1:0];

    acc_cpu_ctrl #(.OW(OW)) u_ctrl (
        .phase         (phase_q),
        .opcode        (opcode),
        .acc_zero      (~|acc_q),
        .ir_ld         (ir_ld),
        .pc_ce         (pc_ce),
        .pc_ld         (pc_ld),
        .addr_sel_opnd (addr_sel_opnd),
        .mem_en        (mem_en),
        .mem_we        (mem_we),
        .acc_ce        (acc_ce),
        .b_sel_mem     (b_sel_mem),
        .alu_op        (alu_op)
    );

    acc_cpu_pc #(.W(DW)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (pc_ce),
        .ld    (pc_ld),
        .d     (operand),
        .q     (pc_q)
    );

    assign alu_b = b_sel_mem ? mem_rdata[DW-1:0] : operand;

    acc_cpu_alu #(.W(DW)) u_alu (
        .a  (acc_q),
        .b  (alu_b),
        .op (alu_op),
        .y  (alu_y)
    );

    // Capture the fetched instruction word
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_ld) ir_q <= mem_rdata;
    end

    // Write the ALU result back at the end of execute
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (acc_ce) acc_q <= alu_y;
    end

    assign mem_addr  = addr_sel_opnd ? operand : pc_q;
    assign mem_wdata = {ir_q[IW-OW-1 -: SPARE_W], {GAP_W{1'b0}}, acc_q};
endmodule

// File: rtl/acc_cpu_checker.sv
// Temporal checks on the processor's phase, counter, accumulator and
// memory strobes; attached to every acc_cpu instance by bind.
module acc_cpu_checker
    import acc_cpu_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PHASE-1:0] phase,
    input logic [DATA_W-1:0]    pc,
    input logic [DATA_W-1:0]    acc,
    input logic [INSTR_W-1:0]   ir,
    input logic                 mem_en,
    input logic                 mem_we
);
    logic [OPC_W-1:0] ir_opc;
    assign ir_opc = ir[INSTR_W-1 -: OPC_W];

    assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase[PH_FETCH] |=> pc == DATA_W'($past(pc) + 1'b1));

    assert_pc_hold_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase[PH_DECODE] |=> $stable(pc));

    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[PH_EXEC] |=> $stable(acc));

    assert_we_store_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase[PH_EXEC] && mem_en && ir_opc == OPC_STORE));

    assert_jz_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && ir_opc == OPC_JZ && acc == '0) |=> pc == $past(ir[DATA_W-1:0]));

    assert_jnz_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && ir_opc == OPC_JNZ && acc == '0) |=> $stable(pc));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && ir_opc > OPC_JNZ) |-> !mem_we);

    assert_nop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[PH_EXEC] && ir_opc > OPC_JNZ) |=> ($stable(acc) && $stable(pc)));
endmodule

bind acc_cpu acc_cpu_checker u_acc_cpu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase_q),
    .pc     (pc_q),
    .acc    (acc_q),
    .ir     (ir_q),
    .mem_en (mem_en),
    .mem_we (mem_we)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/100ps
// Self-checking bench: runs a preloaded program on a behavioural memory and
// compares the fetch-address trace, operand reads and stores with tables.
module acc_cpu_bench;
    localparam int NPROG  = 29;
    localparam int NFETCH = 28;
    localparam int NWR    = 7;

    // {address, word} program image
    localparam logic [23:0] PROG [NPROG] = '{
        24'h00_0005, 24'h01_1003, 24'h02_5080, 24'h03_2009, 24'h04_5081,
        24'h05_303C, 24'h06_5F82, 24'h07_4090, 24'h08_6091, 24'h09_7092,
        24'h0A_5083, 24'h0B_9020, 24'h0C_A010, 24'h10_0000, 24'h11_A030,
        24'h12_9018, 24'h18_B0AA, 24'h19_F7FF, 24'h1A_1A05, 24'h1B_5084,
        24'h1C_0040, 24'h1D_5860, 24'h1E_8060, 24'h40_0077, 24'h41_5085,
        24'h42_8042, 24'h90_1234, 24'h91_00D0, 24'h92_0005
    };
    // Expected fetch address of instruction k
    localparam logic [7:0] EXP_FETCH [NFETCH] = '{
        8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
        8'h0A, 8'h0B, 8'h0C, 8'h10, 8'h11, 8'h12, 8'h18, 8'h19, 8'h1A, 8'h1B,
        8'h1C, 8'h1D, 8'h1E, 8'h60, 8'h40, 8'h41, 8'h42, 8'h42
    };
    // Expected stores {address, data} in order
    localparam logic [23:0] EXP_WR [NWR] = '{
        24'h80_0008, 24'h81_00FF, 24'h82_F03C, 24'h83_00FF,
        24'h84_0005, 24'h60_8040, 24'h85_0077
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_en, mem_we;
    logic [15:0] mem [256];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  f_addr [NFETCH];
    logic        f_ok   [NFETCH];
    logic [7:0]  d_addr [NFETCH];
    logic        d_en   [NFETCH];
    logic [23:0] wr_log [16];
    logic        wr_ph  [16];
    int          nwr = 0;

    always #2.5 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we)
    );

    // Behavioural 256x16 memory with one cycle read latency
    initial begin
        for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        for (int i = 0; i < NPROG; i++) mem[PROG[i][23:16]] <= PROG[i][15:0];
    end
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Watchdog: a hung run is one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: held reset shows a fetch of address 0
        repeat (3) @(negedge clk);
        #1;
        chk(mem_addr == 8'h00 && mem_en && !mem_we,
            $sformatf("R1 reset outputs: actual addr=%h en=%b we=%b expected addr=00 en=1 we=0",
                      mem_addr, mem_en, mem_we));

        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NFETCH * 3; cyc++) begin
            #1;
            if (cyc % 3 == 0) begin
                f_addr[cyc/3] = mem_addr;
                f_ok[cyc/3]   = mem_en && !mem_we;
            end else if (cyc % 3 == 1) begin
                d_addr[cyc/3] = mem_addr;
                d_en[cyc/3]   = mem_en && !mem_we;
            end
            if (mem_en && mem_we && nwr < 16) begin
                wr_log[nwr] = {mem_addr, mem_wdata};
                wr_ph[nwr]  = (cyc % 3 == 2);
                nwr++;
            end
            @(negedge clk);
        end

        // R2 R7 R8 R9: fetch trace covers sequencing, jumps, self-modified jump, no-ops
        for (int k = 0; k < NFETCH; k++) begin
            chk(f_addr[k] == EXP_FETCH[k] && f_ok[k],
                $sformatf("R2 R7 R8 R9 fetch %0d: actual addr=%h rd=%b expected addr=%h rd=1",
                          k, f_addr[k], f_ok[k], EXP_FETCH[k]));
        end

        // R5: operand reads in decode for load/addm/subm; none for move
        chk(d_en[7] && d_addr[7] == 8'h90,
            $sformatf("R5 load read: actual en=%b addr=%h expected en=1 addr=90", d_en[7], d_addr[7]));
        chk(d_en[8] && d_addr[8] == 8'h91,
            $sformatf("R5 addm read: actual en=%b addr=%h expected en=1 addr=91", d_en[8], d_addr[8]));
        chk(d_en[9] && d_addr[9] == 8'h92,
            $sformatf("R5 subm read: actual en=%b addr=%h expected en=1 addr=92", d_en[9], d_addr[9]));
        chk(!d_en[0],
            $sformatf("R5 move decode read: actual en=%b expected en=0", d_en[0]));

        // R9 R10: exactly the expected number of writes, all in execute
        chk(nwr == NWR,
            $sformatf("R9 R10 write count: actual=%0d expected=%0d", nwr, NWR));
        // R3 R4 R5 R6 R7: store contents carry ALU results, spare nibble and built jump
        for (int w = 0; w < NWR; w++) begin
            chk(w < nwr && wr_log[w] == EXP_WR[w] && wr_ph[w],
                $sformatf("R3 R4 R5 R6 R10 store %0d: actual=%h exec=%b expected=%h exec=1",
                          w, wr_log[w], wr_ph[w], EXP_WR[w]));
        end

        // R1: reset in the middle of a run restarts from address 0
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(mem_addr == 8'h00 && mem_en && !mem_we,
            $sformatf("R1 mid-run reset: actual addr=%h en=%b we=%b expected addr=00 en=1 we=0",
                      mem_addr, mem_en, mem_we));
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(mem_addr == 8'(k) && mem_en && !mem_we,
                $sformatf("R1 restart fetch %0d: actual addr=%h expected addr=%h", k, mem_addr, 8'(k)));
            repeat (3) @(negedge clk);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule